// File: doc/BRIEF.md
# Interrupt Source Combiner with Status Register and Supply Wake

This block merges three interrupt causes into one active-low interrupt line. Each cause has its own sticky flag in a readable status word. The three causes are a power failure, a delayed alarm and a periodic tick. Alarm matching, periodic division and voltage sensing are done elsewhere. They arrive here as a one-cycle `alarm_hit` pulse, a one-cycle `periodic_tick` pulse and a level `pwr_fail` flag. The host reads the status word with a single-cycle `status_rd` strobe. That strobe returns a snapshot of the flags and acknowledges every flag at once.

An alarm does not take effect when it arrives. Its flag and the interrupt follow after a wait whose length depends on the selected reference frequency. The block also drives the supply-enable output. Software turns the supply off with a power-down write. Any later interrupt cause turns it back on, but only while `sys_ok` reports a valid system supply.

`irq_n` is a registered, active-low level. At chip level it drives the pull-down of an open-drain pin.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, `irq_n` is 1, `pse` is 1 and `status_rdata` is 0. The status word is 0x10: only the first-time-up flag at bit 4 is set, and that flag never pulls `irq_n` low.
- R2: A rising edge of `pwr_fail` sets status bit 0, and `irq_n` goes low at the following clock edge, provided `pwr_sense_en` is 1 in that cycle. With `pwr_sense_en` at 0, the edge leaves bit 0 clear and `irq_n` high.
- R3: A `periodic_tick` pulse sets status bit 2, and `irq_n` goes low at the following clock edge.
- R4: Status bit 1 and the low `irq_n` appear exactly D clock edges after the edge that samples `alarm_hit`. D is ALARM_DLY when `ref_sel` is 0 or 1, ALARM_DLY/2 when it is 2, and ALARM_DLY/4 when it is 3. Further alarm pulses while a wait is running are merged into that wait.
- R5: A `status_rd` strobe loads `status_rdata` with the status word held before the read edge, at that edge. It also clears bits 0, 1, 2 and 4. If no new cause arrives in that cycle, `irq_n` returns high at the same edge.
- R6: A cause that arrives in the same cycle as `status_rd` is absent from that read's data. It stays set afterwards and keeps `irq_n` low.
- R7: A `pd_write` strobe drives `pse` low at the next edge. `pse` stays low until a wake occurs.
- R8: While `pse` is low, a new interrupt cause in a cycle where `sys_ok` is 1 drives `pse` high at the next edge. A cause seen while `sys_ok` is 0 leaves `pse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ref_sel | input | 2 | Reference frequency: 0 = 32 kHz, 1 = 1 MHz, 2 = 2 MHz, 3 = 4 MHz |
| pwr_fail | input | 1 | Power failure flag (level) |
| pwr_sense_en | input | 1 | Enables power-failure interrupts |
| alarm_hit | input | 1 | One-cycle alarm match pulse |
| periodic_tick | input | 1 | One-cycle selected periodic pulse |
| status_rd | input | 1 | Status read strobe; acknowledges all flags |
| status_rdata | output | 8 | Status word captured by the last read |
| pd_write | input | 1 | Write of one to the power-down control bit |
| sys_ok | input | 1 | System supply valid above battery |
| irq_n | output | 1 | Active-low interrupt |
| pse | output | 1 | Power-supply enable |

## Verification
A status read and a new interrupt cause can land on the same clock edge. The read's clear and the cause's set then act on the same flag register. The bench provokes this by raising the read strobe in the cycle where a power failure edge or a periodic tick arrives, both with and without an older flag pending. It judges the outcome two ways: the returned data must hold only the older flags, and a second read must show that the new flag survived with `irq_n` still low. A power-down write and a wake-up cause can also meet. The bench orders these so that each arrives alone, which keeps the `pse` result unambiguous.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int STAT_W  = 8;
  localparam int NSRC    = 3;
  localparam int BIT_PF  = 0;
  localparam int BIT_ALM = 1;
  localparam int BIT_PER = 2;
  localparam int BIT_FTU = 4;

  typedef enum logic [1:0] {
    REF_32K = 2'd0,
    REF_1M  = 2'd1,
    REF_2M  = 2'd2,
    REF_4M  = 2'd3
  } ref_sel_e;

  function automatic int unsigned ref_shift(input ref_sel_e s);
    case (s)
      REF_2M:  return 1;
      REF_4M:  return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/alarm_delay.sv
module alarm_delay
  import irq_status_pkg::*;
#(
  parameter int ALARM_DLY = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ref_sel,
  input  logic       hit,
  output logic       fire
);
  localparam int CW = $clog2(ALARM_DLY + 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;
  logic [CW-1:0] load_val;

  always_comb begin
    load_val = (CW'(ALARM_DLY) >> ref_shift(ref_sel_e'(ref_sel))) - CW'(1);
  end

  assign fire = active_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - CW'(1);
    end else if (hit) begin
      cnt_q    <= load_val;
      active_q <= 1'b1;
    end
  end

  // R4: the wait counter never exceeds the longest delay
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (cnt_q < CW'(ALARM_DLY)));
  // R4: a fire ends the wait, so the next cycle cannot fire
  p_single_fire_r4: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/status_flags.sv
module status_flags
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_evt,
  input  logic              rd,
  output logic [STAT_W-1:0] rdata,
  output logic              irq_n
);
  logic [NSRC-1:0]   src_q;
  logic [NSRC-1:0]   src_nxt;
  logic              ftu_q;
  logic [STAT_W-1:0] word;

  // clear by read, then set by new events: a same-cycle event survives
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      src_nxt[i] = (src_q[i] & ~rd) | src_evt[i];
    end
  end

  always_comb begin
    word          = '0;
    word[BIT_PF]  = src_q[0];
    word[BIT_ALM] = src_q[1];
    word[BIT_PER] = src_q[2];
    word[BIT_FTU] = ftu_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      ftu_q <= 1'b1;
      rdata <= '0;
      irq_n <= 1'b1;
    end else begin
      src_q <= src_nxt;
      irq_n <= ~(|src_nxt);
      if (rd) begin
        rdata <= word;
        ftu_q <= 1'b0;
      end
    end
  end

  // R5: read data equals the word held before the read edge
  p_read_snapshot_r5: assert property (@(posedge clk) disable iff (rst)
    rd |=> (rdata == $past(word)));
  // R6: an event in the read cycle remains pending
  p_event_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (rd && (|src_evt)) |=> !irq_n);
  // R3: a periodic event lands in its flag
  p_periodic_sets_r3: assert property (@(posedge clk) disable iff (rst)
    src_evt[2] |=> word[BIT_PER]);
  // R1: first-time-up alone keeps the interrupt released
  p_ftu_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (src_q == '0) |-> irq_n);
endmodule

// File: rtl/supply_ctrl.sv
module supply_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic pd_write,
  input  logic wake_evt,
  input  logic sys_ok,
  output logic pse
);
  always_ff @(posedge clk) begin
    if (rst)                           pse <= 1'b1;
    else if (pd_write)                 pse <= 1'b0;
    else if (!pse && wake_evt && sys_ok) pse <= 1'b1;
  end

  // R7: power-down write turns the supply off
  p_pd_off_r7: assert property (@(posedge clk) disable iff (rst)
    pd_write |=> !pse);
  // R8: a valid-supply event wakes the supply
  p_wake_r8: assert property (@(posedge clk) disable iff (rst)
    (!pse && !pd_write && wake_evt && sys_ok) |=> pse);
  // R8: no wake without a valid supply
  p_no_wake_r8: assert property (@(posedge clk) disable iff (rst)
    (!pse && !sys_ok) |=> !pse);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int ALARM_DLY = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ref_sel,
  input  logic              pwr_fail,
  input  logic              pwr_sense_en,
  input  logic              alarm_hit,
  input  logic              periodic_tick,
  input  logic              status_rd,
  output logic [STAT_W-1:0] status_rdata,
  input  logic              pd_write,
  input  logic              sys_ok,
  output logic              irq_n,
  output logic              pse
);
  logic            pf_d;
  logic            pf_evt;
  logic            alm_fire;
  logic [NSRC-1:0] evt;

  always_ff @(posedge clk) begin
    if (rst) pf_d <= 1'b0;
    else     pf_d <= pwr_fail;
  end

  assign pf_evt = pwr_fail && !pf_d && pwr_sense_en;
  assign evt    = {periodic_tick, alm_fire, pf_evt};

  alarm_delay #(.ALARM_DLY(ALARM_DLY)) u_delay (
    .clk(clk), .rst(rst), .ref_sel(ref_sel), .hit(alarm_hit), .fire(alm_fire)
  );

  status_flags u_flags (
    .clk(clk), .rst(rst), .src_evt(evt), .rd(status_rd),
    .rdata(status_rdata), .irq_n(irq_n)
  );

  supply_ctrl u_supply (
    .clk(clk), .rst(rst), .pd_write(pd_write), .wake_evt(|evt),
    .sys_ok(sys_ok), .pse(pse)
  );

  // R2: a qualified power-failure edge pulls the interrupt low
  p_pf_irq_r2: assert property (@(posedge clk) disable iff (rst)
    pf_evt |=> !irq_n);
  // R2: a disabled sense path with no other source keeps the line high
  p_pf_masked_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_n && !pwr_sense_en && !alarm_hit && !alm_fire && !periodic_tick) |=> irq_n);
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  localparam int DLY = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ref_sel = 2'd0;
  logic       pwr_fail = 1'b0, pwr_sense_en = 1'b0, alarm_hit = 1'b0;
  logic       periodic_tick = 1'b0, status_rd = 1'b0, pd_write = 1'b0;
  logic       sys_ok = 1'b0;
  logic [7:0] status_rdata;
  logic       irq_n, pse;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  irq_status_unit #(.ALARM_DLY(DLY)) dut (
    .clk(clk), .rst(rst), .ref_sel(ref_sel), .pwr_fail(pwr_fail),
    .pwr_sense_en(pwr_sense_en), .alarm_hit(alarm_hit),
    .periodic_tick(periodic_tick), .status_rd(status_rd),
    .status_rdata(status_rdata), .pd_write(pd_write), .sys_ok(sys_ok),
    .irq_n(irq_n), .pse(pse)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(output logic [7:0] v);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    v = status_rdata;
  endtask

  task automatic tick_once();
    periodic_tick = 1'b1;
    @(negedge clk);
    periodic_tick = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_n", {7'd0, irq_n}, 8'd1);
    check("R1 pse", {7'd0, pse}, 8'd1);
    check("R1 rdata", status_rdata, 8'h00);
    do_read(v);
    check("R1 first read", v, 8'h10);
    check("R5 irq after read", {7'd0, irq_n}, 8'd1);
    do_read(v);
    check("R5 ftu cleared", v, 8'h00);

    // R3 periodic
    tick_once();
    check("R3 irq low", {7'd0, irq_n}, 8'd0);
    do_read(v);
    check("R3 status", v, 8'h04);
    check("R5 irq released", {7'd0, irq_n}, 8'd1);

    // R2 sweep of sense enable
    for (int s = 0; s < 2; s++) begin
      pwr_sense_en = s[0];
      pwr_fail = 1'b1;
      @(negedge clk);
      check("R2 irq", {7'd0, irq_n}, s ? 8'd0 : 8'd1);
      @(negedge clk);
      pwr_fail = 1'b0;
      check("R2 irq hold", {7'd0, irq_n}, s ? 8'd0 : 8'd1);
      do_read(v);
      check("R2 status", v, s ? 8'h01 : 8'h00);
    end

    // R4 sweep over reference selections
    for (int f = 0; f < 4; f++) begin
      int d;
      d = (f == 2) ? DLY / 2 : (f == 3) ? DLY / 4 : DLY;
      ref_sel = f[1:0];
      alarm_hit = 1'b1;
      for (int j = 0; j <= d; j++) begin
        @(negedge clk);
        alarm_hit = (j == 0 && d > 2);   // second pulse merges
        check($sformatf("R4 ref%0d edge%0d", f, j), {7'd0, irq_n},
              (j >= d) ? 8'd0 : 8'd1);
      end
      alarm_hit = 1'b0;
      do_read(v);
      check("R4 alarm bit", v, 8'h02);
      repeat (d + 2) @(negedge clk);
      check("R4 no second fire", {7'd0, irq_n}, 8'd1);
    end
    ref_sel = 2'd0;

    // R6 read coinciding with a new cause, older flag pending
    tick_once();
    pwr_sense_en = 1'b1;
    pwr_fail = 1'b1;
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    pwr_fail = 1'b0;
    check("R6 read data", status_rdata, 8'h04);
    check("R6 irq held", {7'd0, irq_n}, 8'd0);
    do_read(v);
    check("R6 kept flag", v, 8'h01);
    // R6 read coinciding with a tick, nothing older
    periodic_tick = 1'b1;
    status_rd = 1'b1;
    @(negedge clk);
    periodic_tick = 1'b0;
    status_rd = 1'b0;
    check("R6 empty read", status_rdata, 8'h00);
    check("R6 irq low", {7'd0, irq_n}, 8'd0);
    do_read(v);
    check("R6 tick kept", v, 8'h04);

    // R7 / R8 sweep over supply validity
    for (int s = 0; s < 2; s++) begin
      sys_ok = s[0];
      pd_write = 1'b1;
      @(negedge clk);
      pd_write = 1'b0;
      check("R7 pse low", {7'd0, pse}, 8'd0);
      repeat (3) @(negedge clk);
      check("R7 pse stays low", {7'd0, pse}, 8'd0);
      tick_once();
      check("R8 wake", {7'd0, pse}, s ? 8'd1 : 8'd0);
      do_read(v);
      if (!s) begin
        sys_ok = 1'b1;
        tick_once();
        check("R8 late wake", {7'd0, pse}, 8'd1);
        do_read(v);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule